// File: doc/BRIEF.md
# Stacked Interrupt Register Unit

This block collects up to 32 event lines from one functional unit and presents them to software as four word registers with a single level interrupt output. A source line is recorded only when it rises while its enable bit is set. The recorded bits sit in an identity register, and software clears them by writing ones. A mask register decides which recorded bits may drive the interrupt line. A fourth register reads back the live input levels.

Each source bit is tracked by a small state machine that can hold one recorded event and one more queued behind it. The states are `SLOT_EMPTY` (nothing recorded), `SLOT_HELD` (one event, identity bit reads 1) and `SLOT_STACKED` (one event visible plus one queued). The transitions are named as follows. Record: a qualified rising edge moves `SLOT_EMPTY` to `SLOT_HELD`. Stack: a qualified edge with no clear moves `SLOT_HELD` to `SLOT_STACKED`. Drain: a clear with no edge moves `SLOT_HELD` to `SLOT_EMPTY`. Pop: a clear with no edge moves `SLOT_STACKED` to `SLOT_HELD`. Replace: a clear and an edge in the same cycle leave `SLOT_HELD` or `SLOT_STACKED` where it is. An edge that arrives in `SLOT_STACKED` with no clear is dropped. Because of the queue, software that wants a bit fully quiet must clear it twice.

The register word offsets are identity at 0x8, mask at 0x4, enable at 0xC and live status at 0x0. The register is selected by address bits [3:2], and bits [1:0] are ignored.

Top module: `isr_stack_unit`

## Requirements
- R1: Reset clears identity and enable to zero, sets every mask bit to 1, and holds `irq_o` at 0.
- R2: Reading offset 0x0 returns the current raw `evt_i` levels. A write to 0x0 changes no register.
- R3: An identity bit is recorded only on a rising edge of its `evt_i` bit (low in the previous cycle, high now) while its enable bit (offset 0xC) is 1. A line held high records once, and a line whose enable bit is 0 records nothing.
- R4: Writing offset 0x8 clears each identity bit whose write-data bit is 1 (write-one-to-clear). Bits written 0 are unchanged.
- R5: Each bit holds at most two events. While a second event is queued, the first clear leaves the identity bit at 1 and the second clear takes it to 0. Further edges while two events are held are dropped.
- R6: An edge that lands in the same cycle as a clear of that bit is kept, so the identity bit reads 1 afterwards.
- R7: `irq_o` equals the OR over all bits of (identity AND NOT mask), taken from the register values one clock earlier. A mask bit of 1 blocks its source.
- R8: The mask (offset 0x4) and enable (offset 0xC) registers read back the last full word written to them.
- R9: Writing all ones to mask, then zero to enable, then all ones to identity twice leaves identity at zero and `irq_o` at 0, even with two events queued on every source. Later edges stay unrecorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 32 | Raw event lines, one per source |
| reg_addr | input | 4 | Register byte address; bits [3:2] select the register |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench drives single edges on enabled sources and shows they are recorded. It drives held-high lines and edges on disabled sources, which separates edge detection from level detection and shows that enable gating works. Double and triple pulses on one source, followed by single clears, separate a true two-deep queue from a plain sticky bit and from an unbounded counter. An edge placed in the clear cycle shows whether that event survives. Mask toggles on a recorded bit, and the full quiesce sequence with two events queued on many bits, check the output gating and the shutdown ordering.

// File: rtl/isr_pkg.sv
package isr_pkg;

    // Per-source record depth state
    typedef enum logic [1:0] {
        SLOT_EMPTY   = 2'b00,
        SLOT_HELD    = 2'b01,
        SLOT_STACKED = 2'b10
    } slot_state_e;

    // Register selector values (address bits [3:2])
    localparam int          REG_ADDR_W = 4;
    localparam int          SEL_LSB    = 2;
    localparam logic [1:0]  SEL_STATUS = 2'd0;
    localparam logic [1:0]  SEL_MASK   = 2'd1;
    localparam logic [1:0]  SEL_IDENT  = 2'd2;
    localparam logic [1:0]  SEL_ENABLE = 2'd3;

endpackage

// File: rtl/isr_edge_gate.sv
module isr_edge_gate #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_i,
    input  logic [N_SRC-1:0] en_i,
    output logic [N_SRC-1:0] fire_o
);
    logic [N_SRC-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= src_i;
        end
    end

    // Qualified rising edge: low last cycle, high now, enable set
    assign fire_o = src_i & ~prev_q & en_i;

endmodule

// File: rtl/isr_slot_fsm.sv
module isr_slot_fsm
    import isr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic clr_i,
    output logic held_o,
    output logic stacked_o
);
    slot_state_e state_q;
    slot_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: begin
                if (fire_i) state_d = SLOT_HELD;             // record
            end
            SLOT_HELD: begin
                if (fire_i && !clr_i)      state_d = SLOT_STACKED; // stack
                else if (clr_i && !fire_i) state_d = SLOT_EMPTY;   // drain
                else                       state_d = SLOT_HELD;    // replace / idle
            end
            SLOT_STACKED: begin
                if (clr_i && !fire_i) state_d = SLOT_HELD;   // pop
                else                  state_d = SLOT_STACKED; // replace / drop
            end
            default: state_d = SLOT_EMPTY;
        endcase
    end

    // Outputs
    always_comb begin
        held_o    = 1'b0;
        stacked_o = 1'b0;
        unique case (state_q)
            SLOT_EMPTY:   begin held_o = 1'b0; stacked_o = 1'b0; end
            SLOT_HELD:    begin held_o = 1'b1; stacked_o = 1'b0; end
            SLOT_STACKED: begin held_o = 1'b1; stacked_o = 1'b1; end
            default:      begin held_o = 1'b0; stacked_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/isr_ctrl_regs.sv
module isr_ctrl_regs
    import isr_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic                  we_i,
    input  logic [N_SRC-1:0]      wdata_i,
    input  logic [N_SRC-1:0]      raw_i,
    input  logic [N_SRC-1:0]      ident_i,
    output logic [N_SRC-1:0]      mask_o,
    output logic [N_SRC-1:0]      enable_o,
    output logic [N_SRC-1:0]      clr_o,
    output logic [N_SRC-1:0]      rdata_o
);
    logic [1:0]       sel;
    logic [1:0]       unused_lo;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] enable_q;

    assign sel       = addr_i[SEL_LSB +: 2];
    assign unused_lo = addr_i[SEL_LSB-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            enable_q <= '0;
        end else if (we_i) begin
            if (sel == SEL_MASK)   mask_q   <= wdata_i;
            if (sel == SEL_ENABLE) enable_q <= wdata_i;
        end
    end

    // Write-one-to-clear strobes for the identity slots
    assign clr_o = (we_i && sel == SEL_IDENT) ? wdata_i : '0;

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_STATUS: rdata_o = raw_i;
            SEL_MASK:   rdata_o = mask_q;
            SEL_IDENT:  rdata_o = ident_i;
            SEL_ENABLE: rdata_o = enable_q;
            default:    rdata_o = '0;
        endcase
    end

    assign mask_o   = mask_q;
    assign enable_o = enable_q;

endmodule

// File: rtl/isr_irq_out.sv
module isr_irq_out #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] ident_i,
    input  logic [N_SRC-1:0] mask_i,
    output logic             irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(ident_i & ~mask_i);
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/isr_stack_unit.sv
module isr_stack_unit
    import isr_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      evt_i,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_we,
    input  logic [N_SRC-1:0]      reg_wdata,
    output logic [N_SRC-1:0]      reg_rdata,
    output logic                  irq_o
);
    logic [N_SRC-1:0] fire_vec;
    logic [N_SRC-1:0] clr_vec;
    logic [N_SRC-1:0] held_vec;
    logic [N_SRC-1:0] stacked_vec;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] enable_q;

    isr_edge_gate #(.N_SRC(N_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (evt_i),
        .en_i   (enable_q),
        .fire_o (fire_vec)
    );

    isr_ctrl_regs #(.N_SRC(N_SRC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr),
        .we_i     (reg_we),
        .wdata_i  (reg_wdata),
        .raw_i    (evt_i),
        .ident_i  (held_vec),
        .mask_o   (mask_q),
        .enable_o (enable_q),
        .clr_o    (clr_vec),
        .rdata_o  (reg_rdata)
    );

    for (genvar b = 0; b < N_SRC; b++) begin : g_slot
        isr_slot_fsm u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .fire_i    (fire_vec[b]),
            .clr_i     (clr_vec[b]),
            .held_o    (held_vec[b]),
            .stacked_o (stacked_vec[b])
        );
    end

    isr_irq_out #(.N_SRC(N_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ident_i (held_vec),
        .mask_i  (mask_q),
        .irq_o   (irq_o)
    );

endmodule

// File: rtl/isr_stack_unit_chk.sv
module isr_stack_unit_chk
    import isr_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_SRC-1:0]      evt_i,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic                  reg_we,
    input logic [N_SRC-1:0]      reg_wdata,
    input logic [N_SRC-1:0]      reg_rdata,
    input logic                  irq_o,
    input logic [N_SRC-1:0]      fire_vec,
    input logic [N_SRC-1:0]      held_vec,
    input logic [N_SRC-1:0]      stacked_vec,
    input logic [N_SRC-1:0]      mask_q,
    input logic [N_SRC-1:0]      enable_q
);
    // R1: while reset is held, the next sample shows a quiet unit
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == 1'b0 && held_vec == '0));

    // R2: status offset mirrors the raw lines
    p_status_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[3:2] == SEL_STATUS) |-> (reg_rdata == evt_i));

    // R3: no bit is newly recorded where enable was clear
    p_no_latch_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((held_vec & ~$past(held_vec) & ~$past(enable_q)) == '0));

    // R4: with no edges, a clear write pops one level per written bit
    p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[3:2] == SEL_IDENT && fire_vec == '0) |=>
        (held_vec == ($past(stacked_vec) | ($past(held_vec) & ~$past(reg_wdata)))));

    // R5: a queued event always sits behind a visible one
    p_queue_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((stacked_vec & ~held_vec) == '0));

    // R7: output follows the unmasked identity one clock later
    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(held_vec) & ~$past(mask_q))));

endmodule

bind isr_stack_unit isr_stack_unit_chk #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq_o       (irq_o),
    .fire_vec    (fire_vec),
    .held_vec    (held_vec),
    .stacked_vec (stacked_vec),
    .mask_q      (mask_q),
    .enable_q    (enable_q)
);

// File: tb/isr_stack_unit_bench.sv
`timescale 1ns/1ps
module isr_stack_unit_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  evt = '0;
    logic [3:0]    addr = 4'h0;
    logic          we = 1'b0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int           cnt [N];
    logic [N-1:0] prev_m = '0;
    logic [N-1:0] mask_m = '1;
    logic [N-1:0] en_m = '0;
    logic         irq_m = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    isr_stack_unit u_isr_stack_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr(addr),
        .reg_we(we), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
    );

    function automatic logic [N-1:0] ident_m();
        logic [N-1:0] v;
        for (int b = 0; b < N; b++) v[b] = (cnt[b] > 0);
        return v;
    endfunction

    function automatic logic [N-1:0] exp_rdata();
        case (addr[3:2])
            2'd0: return evt;
            2'd1: return mask_m;
            2'd2: return ident_m();
            default: return en_m;
        endcase
    endfunction

    initial for (int b = 0; b < N; b++) cnt[b] = 0;

    // Model update at the active edge (inputs stable since negedge+1)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < N; b++) cnt[b] = 0;
            prev_m = '0; mask_m = '1; en_m = '0; irq_m = 1'b0;
        end else begin
            logic [N-1:0] rise;
            irq_m = |(ident_m() & ~mask_m);
            rise  = evt & ~prev_m;
            for (int b = 0; b < N; b++) begin
                if (we && addr[3:2] == 2'd2 && wdata[b] && cnt[b] > 0) cnt[b] = cnt[b] - 1;
                if (rise[b] && en_m[b] && cnt[b] < 2) cnt[b] = cnt[b] + 1;
            end
            prev_m = evt;
            if (we && addr[3:2] == 2'd1) mask_m = wdata;
            if (we && addr[3:2] == 2'd3) en_m = wdata;
        end
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (irq !== irq_m || rdata !== exp_rdata()) begin
                fails++;
                $display("FAIL %s cycle %0d: irq=%0d rdata=%h, expected irq=%0d rdata=%h",
                         cur_req, cyc, irq, rdata, irq_m, exp_rdata());
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run hung, got cycle %0d expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // All tasks start and end at negedge+1
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
    endtask

    task automatic wr(input logic [3:0] a, input logic [N-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        step(1);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [N-1:0] exp);
        addr = a;
        @(negedge clk);
        check(req, rdata, exp);
        #1;
    endtask

    task automatic pulse(input logic [N-1:0] bits);
        evt = evt | bits; step(1);
        evt = evt & ~bits; step(1);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1: reset values
        cur_req = "R1";
        rd("R1 mask", 4'h4, '1);
        rd("R1 ident", 4'h8, '0);
        rd("R1 enable", 4'hC, '0);
        check("R1 irq", {31'd0, irq}, '0);

        // R2: live status, writes ignored; R3: disabled edges not recorded
        cur_req = "R2";
        evt = 32'h0000_00A5; step(2);
        rd("R2 status", 4'h0, 32'h0000_00A5);
        wr(4'h1, 32'h1234_5678);   // address 0x1 decodes to status
        rd("R2 status after write", 4'h0, 32'h0000_00A5);
        rd("R2 mask untouched", 4'h4, '1);
        rd("R3 disabled edges", 4'h8, '0);
        evt = '0; step(2);

        // R8: mask and enable read back
        cur_req = "R8";
        wr(4'hC, 32'h0000_00FF);
        rd("R8 enable", 4'hC, 32'h0000_00FF);
        wr(4'h4, 32'hFFFF_FF00);
        rd("R8 mask", 4'h4, 32'hFFFF_FF00);

        // R3: level held high records once; disabled bit 9 ignored
        cur_req = "R3";
        evt = 32'h0000_0201; step(4);
        rd("R3 single record", 4'h8, 32'h0000_0001);
        evt = '0; step(1);

        // R7: unmasked bit drives irq; masking removes it
        cur_req = "R7";
        check("R7 irq set", {31'd0, irq}, 32'd1);
        wr(4'h4, '1); step(1);
        check("R7 irq masked", {31'd0, irq}, 32'd0);
        wr(4'h4, 32'hFFFF_FF00); step(1);
        check("R7 irq unmasked", {31'd0, irq}, 32'd1);

        // R4: write-one-to-clear
        cur_req = "R4";
        wr(4'h8, 32'h0000_0000);
        rd("R4 zero write keeps", 4'h8, 32'h0000_0001);
        wr(4'h8, 32'h0000_0001);
        rd("R4 cleared", 4'h8, 32'h0000_0000);
        step(1);
        check("R4 irq drops", {31'd0, irq}, 32'd0);

        // R5: two-deep queue, third edge dropped
        cur_req = "R5";
        pulse(32'h2); pulse(32'h2);
        wr(4'h8, 32'h2);
        rd("R5 re-exposed", 4'h8, 32'h2);
        wr(4'h8, 32'h2);
        rd("R5 drained", 4'h8, 32'h0);
        pulse(32'h2); pulse(32'h2); pulse(32'h2);
        wr(4'h8, 32'h2); wr(4'h8, 32'h2);
        rd("R5 saturated at two", 4'h8, 32'h0);

        // R6: edge coincident with clear is kept
        cur_req = "R6";
        pulse(32'h4);
        evt = 32'h4; wr(4'h8, 32'h4);
        evt = '0;
        rd("R6 kept", 4'h8, 32'h4);
        wr(4'h8, 32'h4);
        rd("R6 final clear", 4'h8, 32'h0);
        evt = 32'h8; wr(4'h8, 32'h8);   // edge + clear on empty bit
        evt = '0;
        rd("R6 empty slot", 4'h8, 32'h8);
        wr(4'h8, 32'h8);

        // R9: quiesce sequence with two queued on many bits
        cur_req = "R9";
        pulse(32'h0000_00F0); pulse(32'h0000_00F0);
        step(1);
        check("R9 irq before", {31'd0, irq}, 32'd1);
        wr(4'h4, '1);
        wr(4'hC, '0);
        wr(4'h8, '1);
        wr(4'h8, '1);
        rd("R9 ident quiet", 4'h8, '0);
        pulse(32'h0000_00FF);
        rd("R9 no new records", 4'h8, '0);
        step(1);
        check("R9 irq quiet", {31'd0, irq}, 32'd0);

        step(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule